// File: doc/BRIEF.md
# Bit Test and Modify Unit

This block carries out the four single-bit operations on a 16-bit operand: test only, test then set, test then clear, and test then invert. A request presents the operand, the bit index, an operation and a flag that says whether the operand came from a register or from memory. After a fixed number of cycles the block returns the new operand value, a write-enable, the carry flag (the selected bit as it was before any change) and a signed byte offset that the address path adds to the word address of a memory operand.

Two request forms exist. In the register-index form the operation comes from a 2-bit code and the index is a full 16-bit signed value. For a memory operand, the index bits above the low four select a word before or after the addressed one. In the immediate form the operation is taken from the 3-bit middle field (bits 5:3) of the addressing byte, the index is the low four bits of an 8-bit immediate, and no offset is produced. Field values with the top bit clear are not valid operations. They raise an invalid-opcode output and leave the operand and carry alone.

A four-state controller sequences each request. S_IDLE accepts a request (transition IDLE->DECODE on req_valid). S_DECODE registers the chosen operation, bit position, legality and offset (DECODE->APPLY, always). S_APPLY computes and registers the outputs (APPLY->EMIT, always). S_EMIT presents them with done for one cycle (EMIT->IDLE, always). With no request, S_IDLE stays where it is.

Top module: `btm_unit`

## Requirements
- R1: The selected bit position is the index modulo 16, meaning only the low 4 index bits are used. An index of 17 selects bit 1.
- R2: When done is high after a valid operation, carry holds the value the selected bit had before the operation changed anything.
- R3: Test (req_op 00, or field 100) returns the operand unchanged with wr_en low.
- R4: Set (req_op 01 / field 101) ORs in the bit, clear (10 / 110) clears it, invert (11 / 111) flips it. For each of these, wr_en is high in the done cycle only.
- R5: With req_imm low and req_mem high, addr_off equals the arithmetic right shift by 4 of the signed 16-bit index, times 2 bytes. It is 0 for register operands and for the immediate form.
- R6: With req_imm high, the operation comes from req_sub (addressing byte bits 5:3) as listed in R3 and R4, req_op is ignored, and the index is the low 4 bits of req_imm_index.
- R7: With req_imm high and req_sub 000 to 011, bad_op rises with done, wr_en stays low, result equals the operand, and carry keeps the value it had before the request.
- R8: done rises in the third cycle after the cycle in which req_valid is sampled in S_IDLE, and it lasts exactly one cycle. req_valid in any other state is ignored.
- R9: During reset and after it, done, wr_en, bad_op, carry, result and addr_off are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled in S_IDLE |
| req_imm | input | 1 | 1 = immediate form |
| req_op | input | 2 | Register-form operation: 00 test, 01 set, 10 clear, 11 invert |
| req_sub | input | 3 | Immediate-form field (addressing byte bits 5:3) |
| req_mem | input | 1 | 1 = operand is in memory |
| req_operand | input | 16 | Operand value |
| req_index | input | 16 | Register-supplied signed bit index |
| req_imm_index | input | 8 | Immediate bit index |
| done | output | 1 | Results valid, one cycle |
| result | output | 16 | Operand after the operation |
| wr_en | output | 1 | Result must be written back |
| carry | output | 1 | Carry flag |
| addr_off | output | 16 | Signed byte offset for the word address |
| bad_op | output | 1 | Invalid immediate subfunction |

## Verification
A controller stuck in or skipping a state shows up at once as done arriving early, late, lasting more than one cycle, or coming back without a new request. The bench samples done in each cycle around the expected one. A wrong registered operation or bit position shows in the same done cycle as a wrong result, carry or wr_en. A carry register updated on an illegal request shows as a changed carry in that request's done cycle. A stale offset register shows up as a nonzero addr_off on the next register or immediate request.

// File: rtl/btm_pkg.sv
package btm_pkg;
    typedef enum logic [1:0] {
        BOP_TEST  = 2'b00,
        BOP_SET   = 2'b01,
        BOP_CLEAR = 2'b10,
        BOP_FLIP  = 2'b11
    } bop_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DECODE,
        S_APPLY,
        S_EMIT
    } bstate_e;

    localparam int SUB_W = 3;
endpackage

// File: rtl/btm_decode.sv
module btm_decode
    import btm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              imm_form,
    input  logic              is_mem,
    input  bop_e              reg_op,
    input  logic [SUB_W-1:0]  sub_field,
    input  logic [DATA_W-1:0] reg_idx,
    input  logic [IMM_W-1:0]  imm_idx,
    output bop_e              op,
    output logic              legal,
    output logic [IDX_W-1:0]  bit_pos,
    output logic [DATA_W-1:0] addr_off
);
    localparam int BYTES   = DATA_W / 8;
    localparam int BYTE_SH = $clog2(BYTES);

    logic signed [DATA_W-1:0] word_step;
    logic signed [DATA_W-1:0] byte_step;

    // Words beyond the addressed one, then scaled to bytes
    assign word_step = $signed(reg_idx) >>> IDX_W;
    assign byte_step = word_step <<< BYTE_SH;

    always_comb begin
        if (imm_form) begin
            // Field top bit marks the four legal subfunctions
            legal    = sub_field[SUB_W-1];
            op       = bop_e'(sub_field[1:0]);
            bit_pos  = imm_idx[IDX_W-1:0];
            addr_off = '0;
        end else begin
            legal    = 1'b1;
            op       = reg_op;
            bit_pos  = reg_idx[IDX_W-1:0];
            addr_off = is_mem ? byte_step : '0;
        end
    end
endmodule

// File: rtl/btm_alu.sv
module btm_alu
    import btm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  bop_e              op,
    input  logic [IDX_W-1:0]  bit_pos,
    output logic [DATA_W-1:0] result,
    output logic              old_bit,
    output logic              writes
);
    logic [DATA_W-1:0] mask;

    // One-hot select built by compare per lane
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (bit_pos == IDX_W'(g));
    end

    assign old_bit = |(operand & mask);

    always_comb begin
        unique case (op)
            BOP_TEST:  result = operand;
            BOP_SET:   result = operand | mask;
            BOP_CLEAR: result = operand & ~mask;
            BOP_FLIP:  result = operand ^ mask;
            default:   result = operand;
        endcase
        writes = (op != BOP_TEST);
    end
endmodule

// File: rtl/btm_unit.sv
module btm_unit
    import btm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_imm,
    input  logic [1:0]        req_op,
    input  logic [2:0]        req_sub,
    input  logic              req_mem,
    input  logic [15:0]       req_operand,
    input  logic [15:0]       req_index,
    input  logic [7:0]        req_imm_index,
    output logic              done,
    output logic [15:0]       result,
    output logic              wr_en,
    output logic              carry,
    output logic [15:0]       addr_off,
    output logic              bad_op
);
    localparam int IDX_W = $clog2(DATA_W);

    bstate_e state_q, state_d;

    // Captured request
    logic              imm_q, mem_q;
    bop_e              rop_q;
    logic [SUB_W-1:0]  sub_q;
    logic [DATA_W-1:0] idx_q, opnd_q;
    logic [IMM_W-1:0]  iidx_q;

    // Registered decode
    bop_e              dop_q;
    logic              legal_q;
    logic [IDX_W-1:0]  pos_q;
    logic [DATA_W-1:0] off_q;

    // Combinational helpers
    bop_e              dec_op;
    logic              dec_legal;
    logic [IDX_W-1:0]  dec_pos;
    logic [DATA_W-1:0] dec_off;
    logic [DATA_W-1:0] alu_res;
    logic              alu_old, alu_wr;

    btm_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) i_decode (
        .imm_form (imm_q),
        .is_mem   (mem_q),
        .reg_op   (rop_q),
        .sub_field(sub_q),
        .reg_idx  (idx_q),
        .imm_idx  (iidx_q),
        .op       (dec_op),
        .legal    (dec_legal),
        .bit_pos  (dec_pos),
        .addr_off (dec_off)
    );

    btm_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_alu (
        .operand(opnd_q),
        .op     (dop_q),
        .bit_pos(pos_q),
        .result (alu_res),
        .old_bit(alu_old),
        .writes (alu_wr)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_DECODE;
            S_DECODE: state_d = S_APPLY;
            S_APPLY:  state_d = S_EMIT;
            S_EMIT:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Capture and decode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_q   <= 1'b0;
            mem_q   <= 1'b0;
            rop_q   <= BOP_TEST;
            sub_q   <= '0;
            idx_q   <= '0;
            opnd_q  <= '0;
            iidx_q  <= '0;
            dop_q   <= BOP_TEST;
            legal_q <= 1'b0;
            pos_q   <= '0;
            off_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    imm_q  <= req_imm;
                    mem_q  <= req_mem;
                    rop_q  <= bop_e'(req_op);
                    sub_q  <= req_sub;
                    idx_q  <= req_index;
                    opnd_q <= req_operand;
                    iidx_q <= req_imm_index;
                end
                S_DECODE: begin
                    dop_q   <= dec_op;
                    legal_q <= dec_legal;
                    pos_q   <= dec_pos;
                    off_q   <= dec_off;
                end
                default: ;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            result   <= '0;
            wr_en    <= 1'b0;
            carry    <= 1'b0;
            addr_off <= '0;
            bad_op   <= 1'b0;
        end else begin
            done   <= 1'b0;
            wr_en  <= 1'b0;
            bad_op <= 1'b0;
            if (state_q == S_APPLY) begin
                done     <= 1'b1;
                addr_off <= off_q;
                if (legal_q) begin
                    result <= alu_res;
                    wr_en  <= alu_wr;
                    carry  <= alu_old;
                end else begin
                    result <= opnd_q;
                    bad_op <= 1'b1;
                end
            end
        end
    end

    // Checks beside the logic they guard
    p_wr_in_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_from_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_APPLY) |=> (done && state_q == S_EMIT));
    p_test_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && legal_q && dop_q == BOP_TEST) |-> (result == opnd_q && !wr_en));
    p_bad_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (done && !wr_en && result == opnd_q));
    p_carry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bad_op) |-> (carry == $past(carry)));
    p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (imm_q || !mem_q)) |-> (addr_off == '0));
endmodule

// File: tb/test_btm_unit.sv
module test_btm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_imm = 1'b0;
    logic [1:0]  req_op = '0;
    logic [2:0]  req_sub = '0;
    logic        req_mem = 1'b0;
    logic [15:0] req_operand = '0;
    logic [15:0] req_index = '0;
    logic [7:0]  req_imm_index = '0;
    logic        done, wr_en, carry, bad_op;
    logic [15:0] result, addr_off;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    btm_unit i_btm_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_imm(req_imm),
        .req_op(req_op), .req_sub(req_sub), .req_mem(req_mem),
        .req_operand(req_operand), .req_index(req_index),
        .req_imm_index(req_imm_index), .done(done), .result(result),
        .wr_en(wr_en), .carry(carry), .addr_off(addr_off), .bad_op(bad_op)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and check every output in the done cycle
    task automatic run_op(input string tag, input logic imm, input logic [1:0] op,
                          input logic [2:0] sub, input logic mem,
                          input logic [15:0] opnd, input logic [15:0] idx,
                          input logic [7:0] iidx, input logic poke,
                          input logic [15:0] e_res, input logic e_wr,
                          input logic e_c, input logic [15:0] e_off,
                          input logic e_bad);
        @(negedge clk);
        req_imm = imm; req_op = op; req_sub = sub; req_mem = mem;
        req_operand = opnd; req_index = idx; req_imm_index = iidx;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_imm = 1'b0; req_op = 2'b11; req_mem = 1'b1;
            req_operand = 16'hFFFF; req_index = 16'h0100; req_valid = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R8 done early"}, 16'(done), 16'd0);
        @(negedge clk);
        chk({tag, " R8 done"}, 16'(done), 16'd1);
        chk({tag, " result"}, result, e_res);
        chk({tag, " wr_en"}, 16'(wr_en), 16'(e_wr));
        chk({tag, " R2 carry"}, 16'(carry), 16'(e_c));
        chk({tag, " R5 addr_off"}, addr_off, e_off);
        chk({tag, " R7 bad_op"}, 16'(bad_op), 16'(e_bad));
        @(negedge clk);
        chk({tag, " R8 one-cycle done"}, 16'(done), 16'd0);
        chk({tag, " R4 wr_en drop"}, 16'(wr_en), 16'd0);
    endtask

    task automatic t_reset_r9();
        chk("R9 done", 16'(done), 16'd0);
        chk("R9 wr_en", 16'(wr_en), 16'd0);
        chk("R9 bad_op", 16'(bad_op), 16'd0);
        chk("R9 carry", 16'(carry), 16'd0);
        chk("R9 result", result, 16'd0);
        chk("R9 addr_off", addr_off, 16'd0);
    endtask

    task automatic t_register_ops();
        run_op("R3 test bit0", 0, 2'b00, 3'b000, 0, 16'h8421, 16'h0000, 8'h00, 0,
               16'h8421, 0, 1, 16'h0000, 0);
        run_op("R1 set idx17", 0, 2'b01, 3'b000, 0, 16'h0000, 16'd17, 8'h00, 0,
               16'h0002, 1, 0, 16'h0000, 0);
        run_op("R4 clear bit15", 0, 2'b10, 3'b000, 0, 16'hFFFF, 16'd15, 8'h00, 0,
               16'h7FFF, 1, 1, 16'h0000, 0);
        run_op("R4 flip bit4", 0, 2'b11, 3'b000, 0, 16'h00F0, 16'd4, 8'h00, 0,
               16'h00E0, 1, 1, 16'h0000, 0);
        run_op("R5 reg operand no off", 0, 2'b00, 3'b000, 0, 16'h0008, 16'h0023, 8'h00, 0,
               16'h0008, 0, 1, 16'h0000, 0);
    endtask

    task automatic t_memory_offsets_r5();
        run_op("R5 mem +2 words", 0, 2'b01, 3'b000, 1, 16'h0000, 16'h0023, 8'h00, 0,
               16'h0008, 1, 0, 16'h0004, 0);
        run_op("R5 mem -1 word", 0, 2'b00, 3'b000, 1, 16'h8000, 16'hFFFF, 8'h00, 0,
               16'h8000, 0, 1, 16'hFFFE, 0);
        run_op("R5 mem most negative", 0, 2'b10, 3'b000, 1, 16'h0001, 16'h8000, 8'h00, 0,
               16'h0000, 1, 1, 16'hF000, 0);
    endtask

    task automatic t_immediate_r6();
        run_op("R6 imm test", 1, 2'b11, 3'b100, 1, 16'h0020, 16'h0023, 8'h35, 0,
               16'h0020, 0, 1, 16'h0000, 0);
        run_op("R6 imm set", 1, 2'b10, 3'b101, 0, 16'h0000, 16'h0000, 8'hF3, 0,
               16'h0008, 1, 0, 16'h0000, 0);
        run_op("R6 imm clear", 1, 2'b00, 3'b110, 1, 16'h8001, 16'h7FF0, 8'h1F, 0,
               16'h0001, 1, 1, 16'h0000, 0);
        run_op("R6 imm flip", 1, 2'b01, 3'b111, 0, 16'h0001, 16'h0000, 8'h40, 0,
               16'h0000, 1, 1, 16'h0000, 0);
    endtask

    task automatic t_illegal_r7();
        // carry is 1 from the previous flip
        for (int s = 0; s < 4; s++) begin
            run_op("R7 illegal keep c1", 1, 2'b01, 3'(s), 1, 16'h1234, 16'h0040, 8'h00, 0,
                   16'h1234, 0, 1, 16'h0000, 1);
        end
        run_op("R7 prep c0", 0, 2'b01, 3'b000, 0, 16'h0000, 16'h0000, 8'h00, 0,
               16'h0001, 1, 0, 16'h0000, 0);
        run_op("R7 illegal keep c0", 1, 2'b11, 3'b010, 0, 16'hFFFF, 16'h0000, 8'h00, 0,
               16'hFFFF, 0, 0, 16'h0000, 1);
    endtask

    task automatic t_busy_ignore_r8();
        run_op("R8 busy ignored", 0, 2'b01, 3'b000, 0, 16'h0000, 16'd2, 8'h00, 1,
               16'h0004, 1, 0, 16'h0000, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 no second done", 16'(done), 16'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r9();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r9();
        t_register_ops();
        t_memory_offsets_r5();
        t_immediate_r6();
        t_illegal_r7();
        t_busy_ignore_r8();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule